// File: doc/BRIEF.md
# Host Messaging Unit with Queue Ports

This block sits between a 32-bit host register port and an I/O processor. The host moves work through two queue ports. Reading the inbound port hands out a free request tag. Writing the inbound port posts a filled request. Reading the outbound port returns a completed tag. Writing the outbound port gives a processor-memory request back to the free pool. Behind the two ports there are four 16-entry FIFOs. For each one, the processor drives the side the host does not.

A tag whose bit 31 is clear is an offset into the processor's memory. A tag whose bit 31 is set names a host request. Host requests lie on 32-byte boundaries, so the low 31 bits of such a tag hold the bus address shifted right by five. On the processor side, every posted tag comes with its decoded kind and byte address.

Non-queued commands travel through message registers. The host writes a command word into inbound message 0. The processor answers by writing the same word into outbound message 0, and that match is recorded as a status event. A doorbell register and two interrupt status/mask pairs complete the block. The inbound pair drives the processor interrupt and the outbound pair drives the host interrupt.

Top module: `hmu_top`

## Requirements
- R1: After reset, host_rdata is 0 and both interrupt lines are low. Both masks and both status registers read 0. Every queue is empty, so cpu_post_valid and cpu_ret_valid are low.
- R2: A host read at offset 0x40 pops the oldest tag the processor pushed with cpu_free_push, and host_rdata shows it in the cycle after the access. On an empty queue the read returns 0xFFFFFFFF and removes nothing.
- R3: A host write at offset 0x40 appends the word to the post queue. The processor sees the oldest entry on cpu_post_tag while cpu_post_valid is high, and removes it with cpu_post_pop. cpu_post_host equals bit 31 of the tag. When bit 31 is set, cpu_post_addr is the low 27 tag bits shifted left by 5; otherwise cpu_post_addr equals the tag.
- R4: A cpu_done_push into a non-full completion queue sets outbound status bit 1. A host read at offset 0x44 pops completions in push order, and returns 0xFFFFFFFF when the queue is empty.
- R5: A host write at offset 0x44 appends the word to the return queue. The processor reads the return queue in order through cpu_ret_tag, cpu_ret_valid and cpu_ret_pop.
- R6: Each queue holds 16 entries. A push into a full queue is dropped, even if a pop happens in the same cycle. A dropped host push sets inbound status bit 2. A dropped processor push sets outbound status bit 2. Both bits are sticky.
- R7: A host write at 0x10 sets inbound status bit 0. A host write at 0x20 sets inbound status bit 1. Offsets 0x10, 0x14 and 0x20 store their words, which appear on cpu_imsg0, cpu_imsg1 and cpu_doorbell and can be read back. cpu_irq is high exactly when some inbound status bit is 1 and its mask bit (offset 0x28, bits 2:0) is 0.
- R8: cpu_omsg_wr writes cpu_omsg_data into outbound message 0 when cpu_omsg_idx is 0, and into message 1 when cpu_omsg_idx is 1. The host reads these at 0x18 and 0x1C. Outbound status bit 0 is set only by a write to message 0 whose word equals the current inbound message 0.
- R9: Writing to status offsets 0x24 and 0x30 clears each bit where the written word holds a 1. A set event in the same cycle wins over the clear. host_irq is high exactly when some outbound status bit is 1 and its mask bit (offset 0x34, bits 2:0) is 0. Masks read back as written.
- R10: Host writes to 0x18, 0x1C and unmapped offsets change nothing. Host reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe, one access per cycle |
| host_wr | input | 1 | 1 for a write, 0 for a read |
| host_addr | input | ADDR_W | Byte offset in the register window |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Read result, registered, valid the cycle after a read |
| host_irq | output | 1 | Interrupt to the host |
| cpu_free_push | input | 1 | Push a free tag for the host to claim |
| cpu_free_tag | input | 32 | Free tag word |
| cpu_post_pop | input | 1 | Remove the oldest posted request |
| cpu_post_valid | output | 1 | Post queue not empty |
| cpu_post_tag | output | 32 | Oldest posted tag |
| cpu_post_host | output | 1 | Oldest posted tag names a host request |
| cpu_post_addr | output | 32 | Byte address or offset decoded from the oldest tag |
| cpu_done_push | input | 1 | Push a completed tag |
| cpu_done_tag | input | 32 | Completed tag word |
| cpu_ret_pop | input | 1 | Remove the oldest returned tag |
| cpu_ret_valid | output | 1 | Return queue not empty |
| cpu_ret_tag | output | 32 | Oldest returned tag |
| cpu_omsg_wr | input | 1 | Processor write to an outbound message register |
| cpu_omsg_idx | input | 1 | Outbound message register select |
| cpu_omsg_data | input | 32 | Outbound message word |
| cpu_imsg0 | output | 32 | Inbound message 0 contents |
| cpu_imsg1 | output | 32 | Inbound message 1 contents |
| cpu_doorbell | output | 32 | Doorbell contents |
| cpu_irq | output | 1 | Interrupt to the processor |

## Verification
The bench reads every queue port while the queue is empty. A design that moved a pointer on such a read would return stale tags later. It fills queues to 16 and pushes once more, including a push in the same cycle as a pop. This exposes a design that wraps and overwrites, and one that loses the sticky overflow bit. It writes the outbound message twice, first with a wrong word and then with a matching one, to catch echo detection that fires on any write. It also lines a status set up with a write-one clear in the same cycle, which a design that lets the clear win would drop.

// File: rtl/hmu_pkg.sv
package hmu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NSTAT  = 3;
  localparam int unsigned NQ     = 4;

  // register window offsets (host visible layout)
  localparam logic [7:0] OFF_IMSG0 = 8'h10;
  localparam logic [7:0] OFF_IMSG1 = 8'h14;
  localparam logic [7:0] OFF_OMSG0 = 8'h18;
  localparam logic [7:0] OFF_OMSG1 = 8'h1C;
  localparam logic [7:0] OFF_BELL  = 8'h20;
  localparam logic [7:0] OFF_ISTAT = 8'h24;
  localparam logic [7:0] OFF_IMASK = 8'h28;
  localparam logic [7:0] OFF_OSTAT = 8'h30;
  localparam logic [7:0] OFF_OMASK = 8'h34;
  localparam logic [7:0] OFF_INQ   = 8'h40;
  localparam logic [7:0] OFF_OUTQ  = 8'h44;

  // status bit positions
  localparam int unsigned IS_MSG  = 0;
  localparam int unsigned IS_BELL = 1;
  localparam int unsigned IS_OVF  = 2;
  localparam int unsigned OS_ECHO = 0;
  localparam int unsigned OS_DONE = 1;
  localparam int unsigned OS_OVF  = 2;

  // queue indices
  localparam int unsigned Q_FREE = 0;
  localparam int unsigned Q_POST = 1;
  localparam int unsigned Q_DONE = 2;
  localparam int unsigned Q_RET  = 3;

  localparam logic [DATA_W-1:0] EMPTY_WORD = '1;

  function automatic logic tag_is_host(input logic [DATA_W-1:0] tag);
    return tag[DATA_W-1];
  endfunction

  // host tags carry address>>5 below the flag; shifting left drops the flag
  function automatic logic [DATA_W-1:0] tag_to_addr(input logic [DATA_W-1:0] tag);
    return tag_is_host(tag) ? (tag << 5) : tag;
  endfunction
endpackage

// File: rtl/hmu_fifo.sv
module hmu_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         drop
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign drop    = push & full;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R6: occupancy never passes the depth
  a_r6_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R2: a pop from an empty queue leaves it empty
  a_r2_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);

  // R6: a push into a full queue with no pop leaves it full and unchanged
  a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (full && $stable(wr_ptr)));
endmodule

// File: rtl/hmu_irq_bank.sv
module hmu_irq_bank #(
  parameter int unsigned NB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set,
  input  logic          clr_we,
  input  logic          mask_we,
  input  logic [NB-1:0] wdata,
  output logic [NB-1:0] stat,
  output logic [NB-1:0] mask,
  output logic          irq
);
  logic [NB-1:0] clr_bits;

  assign clr_bits = clr_we ? wdata : '0;
  assign irq      = |(stat & ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      mask <= '0;
    end else begin
      stat <= (stat & ~clr_bits) | set;
      if (mask_we) mask <= wdata;
    end
  end

  // R9: a set event always lands, even against a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((stat & $past(set)) == $past(set)));

  // R9: write-one clear with no competing set empties the chosen bits
  a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && set == '0) |=> ((stat & $past(wdata)) == '0));

  // R9: the line only rises after a new event or a mask change
  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|set) || $past(mask_we)));
endmodule

// File: rtl/hmu_top.sv
module hmu_top
  import hmu_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned QDEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_irq,
  input  logic              cpu_free_push,
  input  logic [31:0]       cpu_free_tag,
  input  logic              cpu_post_pop,
  output logic              cpu_post_valid,
  output logic [31:0]       cpu_post_tag,
  output logic              cpu_post_host,
  output logic [31:0]       cpu_post_addr,
  input  logic              cpu_done_push,
  input  logic [31:0]       cpu_done_tag,
  input  logic              cpu_ret_pop,
  output logic              cpu_ret_valid,
  output logic [31:0]       cpu_ret_tag,
  input  logic              cpu_omsg_wr,
  input  logic              cpu_omsg_idx,
  input  logic [31:0]       cpu_omsg_data,
  output logic [31:0]       cpu_imsg0,
  output logic [31:0]       cpu_imsg1,
  output logic [31:0]       cpu_doorbell,
  output logic              cpu_irq
);
  localparam int unsigned PAD = DATA_W - NSTAT;

  // host access decode
  logic rd_any, wr_any;
  logic wr_imsg0, wr_imsg1, wr_bell, wr_istat, wr_imask, wr_ostat, wr_omask;
  logic wr_inq, wr_outq, rd_inq, rd_outq;

  assign rd_any   = host_sel & ~host_wr;
  assign wr_any   = host_sel &  host_wr;
  assign wr_imsg0 = wr_any && (host_addr == ADDR_W'(OFF_IMSG0));
  assign wr_imsg1 = wr_any && (host_addr == ADDR_W'(OFF_IMSG1));
  assign wr_bell  = wr_any && (host_addr == ADDR_W'(OFF_BELL));
  assign wr_istat = wr_any && (host_addr == ADDR_W'(OFF_ISTAT));
  assign wr_imask = wr_any && (host_addr == ADDR_W'(OFF_IMASK));
  assign wr_ostat = wr_any && (host_addr == ADDR_W'(OFF_OSTAT));
  assign wr_omask = wr_any && (host_addr == ADDR_W'(OFF_OMASK));
  assign wr_inq   = wr_any && (host_addr == ADDR_W'(OFF_INQ));
  assign wr_outq  = wr_any && (host_addr == ADDR_W'(OFF_OUTQ));
  assign rd_inq   = rd_any && (host_addr == ADDR_W'(OFF_INQ));
  assign rd_outq  = rd_any && (host_addr == ADDR_W'(OFF_OUTQ));

  // four queues behind the two ports
  logic [NQ-1:0] q_push, q_pop, q_empty, q_full, q_drop;
  logic [31:0]   q_wdata [NQ];
  logic [31:0]   q_head  [NQ];

  assign q_push[Q_FREE]  = cpu_free_push;
  assign q_wdata[Q_FREE] = cpu_free_tag;
  assign q_pop[Q_FREE]   = rd_inq;
  assign q_push[Q_POST]  = wr_inq;
  assign q_wdata[Q_POST] = host_wdata;
  assign q_pop[Q_POST]   = cpu_post_pop;
  assign q_push[Q_DONE]  = cpu_done_push;
  assign q_wdata[Q_DONE] = cpu_done_tag;
  assign q_pop[Q_DONE]   = rd_outq;
  assign q_push[Q_RET]   = wr_outq;
  assign q_wdata[Q_RET]  = host_wdata;
  assign q_pop[Q_RET]    = cpu_ret_pop;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    hmu_fifo #(.W(DATA_W), .DEPTH(QDEPTH)) u_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (q_push[g]),
      .push_data(q_wdata[g]),
      .pop      (q_pop[g]),
      .head     (q_head[g]),
      .empty    (q_empty[g]),
      .full     (q_full[g]),
      .drop     (q_drop[g])
    );
  end

  // message registers
  logic [31:0] imsg0_q, imsg1_q, bell_q, omsg0_q, omsg1_q;
  logic        echo_hit, done_taken, host_drop, cpu_drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imsg0_q <= '0;
      imsg1_q <= '0;
      bell_q  <= '0;
      omsg0_q <= '0;
      omsg1_q <= '0;
    end else begin
      if (wr_imsg0) imsg0_q <= host_wdata;
      if (wr_imsg1) imsg1_q <= host_wdata;
      if (wr_bell)  bell_q  <= host_wdata;
      if (cpu_omsg_wr && !cpu_omsg_idx) omsg0_q <= cpu_omsg_data;
      if (cpu_omsg_wr &&  cpu_omsg_idx) omsg1_q <= cpu_omsg_data;
    end
  end

  // named events feeding the status banks
  assign echo_hit   = cpu_omsg_wr && !cpu_omsg_idx && (cpu_omsg_data == imsg0_q);
  assign done_taken = cpu_done_push && !q_full[Q_DONE];
  assign host_drop  = q_drop[Q_POST] | q_drop[Q_RET];
  assign cpu_drop   = q_drop[Q_FREE] | q_drop[Q_DONE];

  logic [NSTAT-1:0] in_set, out_set, istat, imask, ostat, omask;

  always_comb begin
    in_set          = '0;
    in_set[IS_MSG]  = wr_imsg0;
    in_set[IS_BELL] = wr_bell;
    in_set[IS_OVF]  = host_drop;
    out_set          = '0;
    out_set[OS_ECHO] = echo_hit;
    out_set[OS_DONE] = done_taken;
    out_set[OS_OVF]  = cpu_drop;
  end

  hmu_irq_bank #(.NB(NSTAT)) u_in_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (in_set),
    .clr_we (wr_istat),
    .mask_we(wr_imask),
    .wdata  (host_wdata[NSTAT-1:0]),
    .stat   (istat),
    .mask   (imask),
    .irq    (cpu_irq)
  );

  hmu_irq_bank #(.NB(NSTAT)) u_out_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (out_set),
    .clr_we (wr_ostat),
    .mask_we(wr_omask),
    .wdata  (host_wdata[NSTAT-1:0]),
    .stat   (ostat),
    .mask   (omask),
    .irq    (host_irq)
  );

  // read path, registered
  logic [31:0] rd_word;

  always_comb begin
    unique case (host_addr)
      ADDR_W'(OFF_IMSG0): rd_word = imsg0_q;
      ADDR_W'(OFF_IMSG1): rd_word = imsg1_q;
      ADDR_W'(OFF_OMSG0): rd_word = omsg0_q;
      ADDR_W'(OFF_OMSG1): rd_word = omsg1_q;
      ADDR_W'(OFF_BELL):  rd_word = bell_q;
      ADDR_W'(OFF_ISTAT): rd_word = {{PAD{1'b0}}, istat};
      ADDR_W'(OFF_IMASK): rd_word = {{PAD{1'b0}}, imask};
      ADDR_W'(OFF_OSTAT): rd_word = {{PAD{1'b0}}, ostat};
      ADDR_W'(OFF_OMASK): rd_word = {{PAD{1'b0}}, omask};
      ADDR_W'(OFF_INQ):   rd_word = q_empty[Q_FREE] ? EMPTY_WORD : q_head[Q_FREE];
      ADDR_W'(OFF_OUTQ):  rd_word = q_empty[Q_DONE] ? EMPTY_WORD : q_head[Q_DONE];
      default:            rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rdata <= '0;
    else if (rd_any) host_rdata <= rd_word;
  end

  // processor side views
  assign cpu_post_valid = !q_empty[Q_POST];
  assign cpu_post_tag   = q_head[Q_POST];
  assign cpu_post_host  = tag_is_host(q_head[Q_POST]);
  assign cpu_post_addr  = tag_to_addr(q_head[Q_POST]);
  assign cpu_ret_valid  = !q_empty[Q_RET];
  assign cpu_ret_tag    = q_head[Q_RET];
  assign cpu_imsg0      = imsg0_q;
  assign cpu_imsg1      = imsg1_q;
  assign cpu_doorbell   = bell_q;

  // R2: an empty inbound port reads back all ones
  a_r2_empty_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_inq && q_empty[Q_FREE]) |=> (host_rdata == 32'hFFFF_FFFF));

  // R4: an empty outbound port reads back all ones
  a_r4_empty_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_outq && q_empty[Q_DONE]) |=> (host_rdata == 32'hFFFF_FFFF));

  // R6: a dropped host post marks the inbound overflow bit
  a_r6_host_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_inq && q_full[Q_POST]) || (wr_outq && q_full[Q_RET])) |=> istat[IS_OVF]);

  // R6: a dropped free-tag push marks the outbound overflow bit
  a_r6_cpu_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_free_push && q_full[Q_FREE]) |=> ostat[OS_OVF]);

  // R8: the echo bit only rises after a matching message 0 write
  a_r8_echo_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ostat[OS_ECHO]) |-> $past(cpu_omsg_wr && !cpu_omsg_idx && (cpu_omsg_data == imsg0_q)));

  // R10: host writes cannot alter outbound message 0
  a_r10_omsg_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !(cpu_omsg_wr && !cpu_omsg_idx)) |=> $stable(omsg0_q));
endmodule

// File: tb/sim_hmu_top.sv
module sim_hmu_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 0, host_wr = 0;
  logic [7:0]  host_addr = 0;
  logic [31:0] host_wdata = 0;
  logic [31:0] host_rdata;
  logic        host_irq;
  logic        cpu_free_push = 0, cpu_post_pop = 0, cpu_done_push = 0, cpu_ret_pop = 0;
  logic [31:0] cpu_free_tag = 0, cpu_done_tag = 0, cpu_omsg_data = 0;
  logic        cpu_omsg_wr = 0, cpu_omsg_idx = 0;
  logic        cpu_post_valid, cpu_post_host, cpu_ret_valid, cpu_irq;
  logic [31:0] cpu_post_tag, cpu_post_addr, cpu_ret_tag;
  logic [31:0] cpu_imsg0, cpu_imsg1, cpu_doorbell;

  always #(CLK_PERIOD/2) clk = ~clk;

  hmu_top u0 (
    .clk(clk), .rst_n(rst_n),
    .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
    .cpu_free_push(cpu_free_push), .cpu_free_tag(cpu_free_tag),
    .cpu_post_pop(cpu_post_pop), .cpu_post_valid(cpu_post_valid),
    .cpu_post_tag(cpu_post_tag), .cpu_post_host(cpu_post_host),
    .cpu_post_addr(cpu_post_addr),
    .cpu_done_push(cpu_done_push), .cpu_done_tag(cpu_done_tag),
    .cpu_ret_pop(cpu_ret_pop), .cpu_ret_valid(cpu_ret_valid), .cpu_ret_tag(cpu_ret_tag),
    .cpu_omsg_wr(cpu_omsg_wr), .cpu_omsg_idx(cpu_omsg_idx), .cpu_omsg_data(cpu_omsg_data),
    .cpu_imsg0(cpu_imsg0), .cpu_imsg1(cpu_imsg1), .cpu_doorbell(cpu_doorbell),
    .cpu_irq(cpu_irq)
  );

  // reference model state
  logic [31:0] mq_free[$], mq_post[$], mq_done[$], mq_ret[$];
  logic [31:0] m_rdata, m_imsg0, m_imsg1, m_bell, m_omsg0, m_omsg1, m_word;
  logic [2:0]  m_is, m_im, m_os, m_om, is_set, os_set, is_clr, os_clr;
  logic        rdn, wrn, full_free, full_post, full_done, full_ret;
  int          n_vec = 0, n_bad = 0;
  string       req = "R1";
  bit          done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq_free.delete(); mq_post.delete(); mq_done.delete(); mq_ret.delete();
      m_rdata = 0; m_imsg0 = 0; m_imsg1 = 0; m_bell = 0; m_omsg0 = 0; m_omsg1 = 0;
      m_is = 0; m_im = 0; m_os = 0; m_om = 0;
    end else begin
      rdn = host_sel && !host_wr;
      wrn = host_sel && host_wr;
      full_free = mq_free.size() >= 16;
      full_post = mq_post.size() >= 16;
      full_done = mq_done.size() >= 16;
      full_ret  = mq_ret.size()  >= 16;
      if (rdn) begin
        case (host_addr)
          8'h10: m_word = m_imsg0;
          8'h14: m_word = m_imsg1;
          8'h18: m_word = m_omsg0;
          8'h1C: m_word = m_omsg1;
          8'h20: m_word = m_bell;
          8'h24: m_word = {29'd0, m_is};
          8'h28: m_word = {29'd0, m_im};
          8'h30: m_word = {29'd0, m_os};
          8'h34: m_word = {29'd0, m_om};
          8'h40: m_word = (mq_free.size() > 0) ? mq_free[0] : 32'hFFFF_FFFF;
          8'h44: m_word = (mq_done.size() > 0) ? mq_done[0] : 32'hFFFF_FFFF;
          default: m_word = 0;
        endcase
        m_rdata = m_word;
      end
      is_set = 0; os_set = 0;
      is_set[0] = wrn && host_addr == 8'h10;
      is_set[1] = wrn && host_addr == 8'h20;
      is_set[2] = (wrn && host_addr == 8'h40 && full_post) || (wrn && host_addr == 8'h44 && full_ret);
      os_set[0] = cpu_omsg_wr && !cpu_omsg_idx && cpu_omsg_data == m_imsg0;
      os_set[1] = cpu_done_push && !full_done;
      os_set[2] = (cpu_free_push && full_free) || (cpu_done_push && full_done);
      is_clr = (wrn && host_addr == 8'h24) ? host_wdata[2:0] : 3'b0;
      os_clr = (wrn && host_addr == 8'h30) ? host_wdata[2:0] : 3'b0;
      // queues: pops act on entries present before the edge
      if (rdn && host_addr == 8'h40 && mq_free.size() > 0) void'(mq_free.pop_front());
      if (cpu_post_pop && mq_post.size() > 0) void'(mq_post.pop_front());
      if (rdn && host_addr == 8'h44 && mq_done.size() > 0) void'(mq_done.pop_front());
      if (cpu_ret_pop && mq_ret.size() > 0) void'(mq_ret.pop_front());
      if (cpu_free_push && !full_free) mq_free.push_back(cpu_free_tag);
      if (wrn && host_addr == 8'h40 && !full_post) mq_post.push_back(host_wdata);
      if (cpu_done_push && !full_done) mq_done.push_back(cpu_done_tag);
      if (wrn && host_addr == 8'h44 && !full_ret) mq_ret.push_back(host_wdata);
      m_is = (m_is & ~is_clr) | is_set;
      m_os = (m_os & ~os_clr) | os_set;
      if (wrn && host_addr == 8'h28) m_im = host_wdata[2:0];
      if (wrn && host_addr == 8'h34) m_om = host_wdata[2:0];
      if (cpu_omsg_wr && !cpu_omsg_idx) m_omsg0 = cpu_omsg_data;
      if (cpu_omsg_wr && cpu_omsg_idx)  m_omsg1 = cpu_omsg_data;
      if (wrn && host_addr == 8'h10) m_imsg0 = host_wdata;
      if (wrn && host_addr == 8'h14) m_imsg1 = host_wdata;
      if (wrn && host_addr == 8'h20) m_bell = host_wdata;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("host_rdata", host_rdata, m_rdata);
      chk("host_irq", {31'd0, host_irq}, {31'd0, |(m_os & ~m_om)});
      chk("cpu_irq", {31'd0, cpu_irq}, {31'd0, |(m_is & ~m_im)});
      chk("cpu_post_valid", {31'd0, cpu_post_valid}, {31'd0, mq_post.size() > 0});
      if (mq_post.size() > 0) begin
        chk("cpu_post_tag", cpu_post_tag, mq_post[0]);
        chk("cpu_post_host", {31'd0, cpu_post_host}, {31'd0, mq_post[0][31]});
        chk("cpu_post_addr", cpu_post_addr,
            mq_post[0][31] ? {mq_post[0][26:0], 5'b0} : mq_post[0]);
      end
      chk("cpu_ret_valid", {31'd0, cpu_ret_valid}, {31'd0, mq_ret.size() > 0});
      if (mq_ret.size() > 0) chk("cpu_ret_tag", cpu_ret_tag, mq_ret[0]);
      chk("cpu_imsg0", cpu_imsg0, m_imsg0);
      chk("cpu_imsg1", cpu_imsg1, m_imsg1);
      chk("cpu_doorbell", cpu_doorbell, m_bell);
    end
  end

  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
    host_sel = 0; host_wr = 0;
    cpu_free_push = 0; cpu_post_pop = 0; cpu_done_push = 0; cpu_ret_pop = 0;
    cpu_omsg_wr = 0;
  endtask

  task automatic hw(input logic [7:0] a, input logic [31:0] d);
    host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
    step();
  endtask

  task automatic hr(input logic [7:0] a);
    host_sel = 1; host_wr = 0; host_addr = a;
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog %s: actual timeout expected finish", req);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*3 + CLK_PERIOD/4);
    rst_n = 1;
    step();
    // R1 reset state
    req = "R1";
    idle(2);
    hr(8'h28); hr(8'h34); hr(8'h24); hr(8'h30); hr(8'h40); idle(1);

    // R2 free tags out of the inbound port, empty read leaves pointers
    req = "R2";
    hr(8'h40); hr(8'h40);
    cpu_free_push = 1; cpu_free_tag = 32'h0000_1000; step();
    cpu_free_push = 1; cpu_free_tag = 32'h0000_1040; step();
    cpu_free_push = 1; cpu_free_tag = 32'h0000_1080; step();
    hr(8'h40); hr(8'h40); hr(8'h40); hr(8'h40); hr(8'h40);
    cpu_free_push = 1; cpu_free_tag = 32'h0000_2200; host_sel = 1; host_wr = 0; host_addr = 8'h40; step();
    hr(8'h40); hr(8'h40); idle(1);

    // R3 posting both tag kinds
    req = "R3";
    hw(8'h40, 32'h0000_2000);
    hw(8'h40, 32'h8000_0000 | (32'h1234_5660 >> 5));
    hw(8'h40, 32'h8000_0000 | (32'hFFFF_FFE0 >> 5));
    idle(1);
    cpu_post_pop = 1; step();
    cpu_post_pop = 1; step();
    cpu_post_pop = 1; step();
    cpu_post_pop = 1; step();
    idle(1);

    // R4 completions and host interrupt
    req = "R4";
    hr(8'h44);
    cpu_done_push = 1; cpu_done_tag = 32'h0000_1040; step();
    cpu_done_push = 1; cpu_done_tag = 32'h8091_A2B3; step();
    hr(8'h30); hr(8'h44); hr(8'h44); hr(8'h44);
    hw(8'h30, 32'h2); idle(1);

    // R5 freed tags back to the processor
    req = "R5";
    hw(8'h44, 32'h0000_1040); hw(8'h44, 32'h0000_1080);
    cpu_ret_pop = 1; step();
    hw(8'h44, 32'h0000_10C0);
    cpu_ret_pop = 1; step();
    cpu_ret_pop = 1; step();
    cpu_ret_pop = 1; step();

    // R6 overflow on every side
    req = "R6";
    for (int i = 0; i < 17; i++) hw(8'h40, 32'h0000_3000 + 32'(i * 64));
    hr(8'h24);
    host_sel = 1; host_wr = 1; host_addr = 8'h40; host_wdata = 32'hDEAD_0000; cpu_post_pop = 1; step();
    for (int i = 0; i < 17; i++) begin cpu_post_pop = 1; step(); end
    hw(8'h24, 32'h4); hr(8'h24);
    for (int i = 0; i < 17; i++) begin cpu_free_push = 1; cpu_free_tag = 32'h0000_4000 + 32'(i); step(); end
    hr(8'h30);
    for (int i = 0; i < 17; i++) hr(8'h40);
    for (int i = 0; i < 17; i++) begin cpu_done_push = 1; cpu_done_tag = 32'h0000_5000 + 32'(i); step(); end
    for (int i = 0; i < 17; i++) hw(8'h44, 32'h0000_6000 + 32'(i));
    hr(8'h24);
    for (int i = 0; i < 17; i++) hr(8'h44);
    for (int i = 0; i < 17; i++) begin cpu_ret_pop = 1; step(); end
    hw(8'h30, 32'h7); hw(8'h24, 32'h7); idle(1);

    // R7 inbound messages, doorbell, processor interrupt mask
    req = "R7";
    hw(8'h10, 32'hC0DE_0001); hr(8'h24);
    hw(8'h14, 32'h5555_AAAA); hr(8'h14);
    hw(8'h28, 32'h1); hr(8'h28);
    hw(8'h24, 32'h1);
    hw(8'h20, 32'h0000_0080); hr(8'h20);
    hw(8'h28, 32'h3); idle(1);
    hw(8'h28, 32'h0); hw(8'h24, 32'h7); idle(1);

    // R8 outbound message echo
    req = "R8";
    cpu_omsg_wr = 1; cpu_omsg_idx = 0; cpu_omsg_data = 32'hC0DE_0002; step();
    hr(8'h30); hr(8'h18);
    cpu_omsg_wr = 1; cpu_omsg_idx = 1; cpu_omsg_data = 32'hC0DE_0001; step();
    hr(8'h30); hr(8'h1C);
    cpu_omsg_wr = 1; cpu_omsg_idx = 0; cpu_omsg_data = 32'hC0DE_0001; step();
    hr(8'h30); hr(8'h18);

    // R9 clear, set-over-clear, host mask
    req = "R9";
    hw(8'h34, 32'h1); hr(8'h34);
    hw(8'h30, 32'h1); hr(8'h30);
    cpu_done_push = 1; cpu_done_tag = 32'h0000_7000; step();
    cpu_done_push = 1; cpu_done_tag = 32'h0000_7040;
    host_sel = 1; host_wr = 1; host_addr = 8'h30; host_wdata = 32'h2; step();
    hr(8'h30);
    hw(8'h34, 32'h2); idle(1);
    hw(8'h34, 32'h0); hw(8'h30, 32'h2); hr(8'h30);
    hr(8'h44); hr(8'h44); hr(8'h44);

    // R10 writes with no effect, unmapped reads
    req = "R10";
    hw(8'h18, 32'h1111_1111); hr(8'h18);
    hw(8'h1C, 32'h2222_2222); hr(8'h1C);
    hw(8'h7C, 32'hFFFF_FFFF); hr(8'h7C);
    hw(8'h2C, 32'h7); hr(8'h24); hr(8'h30); hr(8'h00);
    idle(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule